// File: doc/BRIEF.md
# Level-Sensitive Dual-Output Interrupt Controller

This block gathers up to 64 active-high, level-sensitive interrupt sources and presents them to a processor on two lines: a normal interrupt line and a fast interrupt line. Each source has an enable bit and a routing bit. A source that is asserted and enabled drives exactly one of the two lines, and its routing bit chooses which. Software reads the raw input levels and one masked view per output line. For each line it can also read the lowest-numbered source that is pending there.

Sources are grouped in banks of 32. A build parameter sets 32 or 64 sources. The second bank has its own raw, enable, routing and masked-status registers. All access goes through a single-word register port that accepts one request per cycle. A read returns its data one cycle after the request. No pending state is latched, so a pending bit clears only when its input line drops.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: Each source input passes through a two-flop synchroniser. A level presented before clock edge k shows in the raw status (0x00 for sources 0..31, 0x20 for sources 32..63, source n at bit n mod 32) and on the output lines after edge k+1. The bit follows the input level and has no software clear.
- R2: The enable registers (0x04 lower bank, 0x24 upper bank) and the routing registers (0x08 lower, 0x28 upper) read back the value last written. A write takes effect on the clock edge that accepts it, and the registers never change without a write.
- R3: After reset, all enable bits, all routing bits and the priority storage are zero, and both output lines are low.
- R4: The normal-line status (0x0C lower, 0x2C upper) equals raw AND enable AND NOT routing. The fast-line status (0x10 lower, 0x30 upper) equals raw AND enable AND routing. A routing bit of 0 selects the normal line and 1 selects the fast line.
- R5: The normal output is the OR of every normal-line status bit, and the fast output is the OR of every fast-line status bit. Both follow an enable or routing write in the cycle after the accepting edge.
- R6: Offset 0x18 (normal line) and offset 0x1C (fast line) return the lowest pending source number in bits [5:0], with all other bits zero. When that line has nothing pending, they return 0x8000_0000.
- R7: Offset 0x14 is 32-bit read/write storage with no other effect. In the 64-source build, bit 0 of offset 0x34 is read/write and its other bits read zero.
- R8: Writes to the status and highest-pending offsets are ignored. Reads of any other offset return zero, and so do reads of all upper-bank offsets and 0x34 in the 32-source build.
- R9: The request-ready output is always high. An accepted read raises the response-valid output for exactly the next cycle, carrying the data. A write raises no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Level interrupt sources, active high |
| reqValid | input | 1 | Register request valid |
| reqReady | output | 1 | Register request ready (always high) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 8 | Byte offset of the register |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Read data |
| irqOut | output | 1 | Normal interrupt line |
| fiqOut | output | 1 | Fast interrupt line |

## Verification
A source level change shows in raw status and on the lines two edges after it is driven. The bench therefore holds every source change for two falling edges before it updates its model or samples a line. The lines change one cycle after a register write, so they are checked at the falling edge right after the accepting edge. Read data appears at the falling edge that follows acceptance. Every register comparison samples there, together with response-valid. A second instance built for 32 sources shares the stimulus, so the check that its upper-bank offsets read zero runs under the same traffic.

// File: rtl/irq_fiq_pkg.sv
package irq_fiq_pkg;

  typedef enum logic [3:0] {
    REG_RAW0, REG_EN0, REG_SEL0, REG_IST0, REG_FST0,
    REG_PRIO, REG_IHI, REG_FHI,
    REG_RAW1, REG_EN1, REG_SEL1, REG_IST1, REG_FST1,
    REG_ERR, REG_NONE
  } regIdT;

  typedef struct packed {
    logic        wrEn0;
    logic        wrEn1;
    logic        wrSel0;
    logic        wrSel1;
    logic        wrPrio;
    logic        wrErr;
    logic        rdFire;
    regIdT       rdId;
    logic [31:0] wdata;
  } ctlStrobesT;

  function automatic regIdT decodeOffset(input logic [7:0] addr, input bit hasUpper);
    regIdT id;
    case (addr)
      8'h00: id = REG_RAW0;
      8'h04: id = REG_EN0;
      8'h08: id = REG_SEL0;
      8'h0C: id = REG_IST0;
      8'h10: id = REG_FST0;
      8'h14: id = REG_PRIO;
      8'h18: id = REG_IHI;
      8'h1C: id = REG_FHI;
      8'h20: id = hasUpper ? REG_RAW1 : REG_NONE;
      8'h24: id = hasUpper ? REG_EN1  : REG_NONE;
      8'h28: id = hasUpper ? REG_SEL1 : REG_NONE;
      8'h2C: id = hasUpper ? REG_IST1 : REG_NONE;
      8'h30: id = hasUpper ? REG_FST1 : REG_NONE;
      8'h34: id = hasUpper ? REG_ERR  : REG_NONE;
      default: id = REG_NONE;
    endcase
    return id;
  endfunction

endpackage

// File: rtl/irq_fiq_lowest_pick.sv
module irq_fiq_lowest_pick #(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0] vecIn,
  output logic [31:0]        pickOut
);
  logic [5:0] idx;
  logic       anySet;

  always_comb begin
    idx = 6'd0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (vecIn[i]) idx = 6'(i);
    end
    anySet = |vecIn;
    pickOut = anySet ? {26'd0, idx} : 32'h8000_0000;
  end
endmodule

// File: rtl/irq_fiq_ctrl_unit.sv
module irq_fiq_ctrl_unit
  import irq_fiq_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [7:0]  reqAddr,
  input  logic [31:0] reqWdata,
  output logic        reqReady,
  output logic        rspValid,
  output ctlStrobesT  stb
);
  localparam bit HAS_UPPER = (NUM_SRC > 32);

  logic  accept;
  regIdT reqId;

  assign reqReady = 1'b1;
  assign accept   = reqValid & reqReady;
  assign reqId    = decodeOffset(reqAddr, HAS_UPPER);

  always_comb begin
    stb        = '0;
    stb.wdata  = reqWdata;
    stb.rdId   = reqId;
    stb.rdFire = accept & ~reqWrite;
    if (accept && reqWrite) begin
      case (reqId)
        REG_EN0:  stb.wrEn0  = 1'b1;
        REG_EN1:  stb.wrEn1  = 1'b1;
        REG_SEL0: stb.wrSel0 = 1'b1;
        REG_SEL1: stb.wrSel1 = 1'b1;
        REG_PRIO: stb.wrPrio = 1'b1;
        REG_ERR:  stb.wrErr  = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= stb.rdFire;
  end

  a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rspValid);
  a_r9_no_rsp_otherwise: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || reqWrite) |=> !rspValid);
endmodule

// File: rtl/irq_fiq_datapath.sv
module irq_fiq_datapath
  import irq_fiq_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  ctlStrobesT         stb,
  output logic [31:0]        rspData,
  output logic               irqOut,
  output logic               fiqOut
);
  localparam int BANKS = NUM_SRC / 32;

  logic [NUM_SRC-1:0] syncMid, rawSync, enReg, selReg, irqVec, fiqVec;
  logic [63:0]        rawPad, enPad, selPad, irqPad, fiqPad;
  logic [31:0]        prioReg, irqHigh, fiqHigh, readVal;
  logic               errReg;
  logic [1:0]         wrEnBank, wrSelBank;

  assign wrEnBank  = {stb.wrEn1, stb.wrEn0};
  assign wrSelBank = {stb.wrSel1, stb.wrSel0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMid <= '0;
      rawSync <= '0;
    end else begin
      syncMid <= srcIn;
      rawSync <= syncMid;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enReg[b*32 +: 32]  <= '0;
        selReg[b*32 +: 32] <= '0;
      end else begin
        if (wrEnBank[b])  enReg[b*32 +: 32]  <= stb.wdata;
        if (wrSelBank[b]) selReg[b*32 +: 32] <= stb.wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioReg <= '0;
      errReg  <= 1'b0;
    end else begin
      if (stb.wrPrio) prioReg <= stb.wdata;
      if (stb.wrErr)  errReg  <= stb.wdata[0];
    end
  end

  assign irqVec = rawSync & enReg & ~selReg;
  assign fiqVec = rawSync & enReg & selReg;
  assign irqOut = |irqVec;
  assign fiqOut = |fiqVec;

  irq_fiq_lowest_pick #(.NUM_SRC(NUM_SRC)) irqPick_i (.vecIn(irqVec), .pickOut(irqHigh));
  irq_fiq_lowest_pick #(.NUM_SRC(NUM_SRC)) fiqPick_i (.vecIn(fiqVec), .pickOut(fiqHigh));

  assign rawPad = 64'(rawSync);
  assign enPad  = 64'(enReg);
  assign selPad = 64'(selReg);
  assign irqPad = 64'(irqVec);
  assign fiqPad = 64'(fiqVec);

  always_comb begin
    case (stb.rdId)
      REG_RAW0: readVal = rawPad[31:0];
      REG_EN0:  readVal = enPad[31:0];
      REG_SEL0: readVal = selPad[31:0];
      REG_IST0: readVal = irqPad[31:0];
      REG_FST0: readVal = fiqPad[31:0];
      REG_PRIO: readVal = prioReg;
      REG_IHI:  readVal = irqHigh;
      REG_FHI:  readVal = fiqHigh;
      REG_RAW1: readVal = rawPad[63:32];
      REG_EN1:  readVal = enPad[63:32];
      REG_SEL1: readVal = selPad[63:32];
      REG_IST1: readVal = irqPad[63:32];
      REG_FST1: readVal = fiqPad[63:32];
      REG_ERR:  readVal = {31'd0, errReg};
      default:  readVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rspData <= '0;
    else if (stb.rdFire) rspData <= readVal;
  end

  a_r2_en_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn0 |=> $stable(enReg[31:0]));
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrSel0 |=> $stable(selReg[31:0]));
  a_r6_irq_pick_pending: assert property (@(posedge clk) disable iff (!rstN)
    !irqHigh[31] |-> irqPad[irqHigh[5:0]]);
  a_r6_none_line_low: assert property (@(posedge clk) disable iff (!rstN)
    irqHigh[31] |-> !irqOut);
  a_r6_fiq_none_line_low: assert property (@(posedge clk) disable iff (!rstN)
    fiqHigh[31] |-> !fiqOut);
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import irq_fiq_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [7:0]         reqAddr,
  input  logic [31:0]        reqWdata,
  output logic               rspValid,
  output logic [31:0]        rspData,
  output logic               irqOut,
  output logic               fiqOut
);
  ctlStrobesT stb;

  initial begin
    if (NUM_SRC != 32 && NUM_SRC != 64) $error("NUM_SRC must be 32 or 64");
  end

  irq_fiq_ctrl_unit #(.NUM_SRC(NUM_SRC)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .stb(stb)
  );

  irq_fiq_datapath #(.NUM_SRC(NUM_SRC)) dp_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .stb(stb),
    .rspData(rspData), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  a_r5_lines_exclusive_src: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut || fiqOut) |-> $past(|srcIn) || (|srcIn) || $past(irqOut || fiqOut));
endmodule

// File: tb/irq_fiq_ctrl_tb_top.sv
module irq_fiq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcIn = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, rspValid, irqOut, fiqOut;
  logic [31:0] rspData;
  logic        reqReady32, rspValid32, irqOut32, fiqOut32;
  logic [31:0] rspData32;

  int tests = 0, fails = 0;
  logic [63:0] mEn = '0, mSel = '0, mRaw = '0;
  logic [31:0] rd, rd32;

  always #2 clk = ~clk;

  irq_fiq_ctrl #(.NUM_SRC(64)) dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .irqOut(irqOut), .fiqOut(fiqOut));

  irq_fiq_ctrl #(.NUM_SRC(32)) dut32_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn[31:0]), .reqValid(reqValid), .reqReady(reqReady32),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid32), .rspData(rspData32), .irqOut(irqOut32), .fiqOut(fiqOut32));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expHigh(input logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return 32'(i);
    return 32'h8000_0000;
  endfunction

  task automatic regWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    check("R9", "no response on write", {31'd0, rspValid}, 32'd0);
  endtask

  task automatic regRd(input logic [7:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    rd = rspData; rd32 = rspData32;
    check("R9", "response valid after read", {31'd0, rspValid}, 32'd1);
  endtask

  task automatic setSrc(input logic [63:0] v);
    @(negedge clk);
    srcIn = v;
    repeat (2) @(negedge clk);
    mRaw = v;
  endtask

  task automatic checkAll();
    logic [63:0] iv, fv;
    iv = mRaw & mEn & ~mSel;
    fv = mRaw & mEn & mSel;
    check("R5", "irqOut", {31'd0, irqOut}, {31'd0, |iv});
    check("R5", "fiqOut", {31'd0, fiqOut}, {31'd0, |fv});
    check("R8", "irqOut of 32-source build", {31'd0, irqOut32}, {31'd0, |iv[31:0]});
    regRd(8'h00); check("R1", "raw lower", rd, mRaw[31:0]);
    regRd(8'h20); check("R1", "raw upper", rd, mRaw[63:32]);
    check("R8", "upper raw in 32 build", rd32, 32'd0);
    regRd(8'h0C); check("R4", "irq status lower", rd, iv[31:0]);
    regRd(8'h2C); check("R4", "irq status upper", rd, iv[63:32]);
    regRd(8'h10); check("R4", "fiq status lower", rd, fv[31:0]);
    regRd(8'h30); check("R4", "fiq status upper", rd, fv[63:32]);
    regRd(8'h18); check("R6", "highest irq", rd, expHigh(iv));
    regRd(8'h1C); check("R6", "highest fiq", rd, expHigh(fv));
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7421));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R3 reset state
    check("R3", "irqOut after reset", {31'd0, irqOut}, 32'd0);
    check("R3", "fiqOut after reset", {31'd0, fiqOut}, 32'd0);
    check("R9", "ready high", {31'd0, reqReady}, 32'd1);
    regRd(8'h04); check("R3", "enable lower reset", rd, 32'd0);
    regRd(8'h28); check("R3", "select upper reset", rd, 32'd0);
    regRd(8'h14); check("R3", "priority reset", rd, 32'd0);

    // R1 synchroniser latency with source 5 enabled
    regWr(8'h04, 32'h20); mEn[5] = 1'b1;
    @(negedge clk); srcIn[5] = 1'b1;
    @(negedge clk); check("R1", "line low one edge after source", {31'd0, irqOut}, 32'd0);
    @(negedge clk); check("R1", "line high two edges after source", {31'd0, irqOut}, 32'd1);
    mRaw[5] = 1'b1;
    // R5 routing change updates lines right after accepting edge
    regWr(8'h08, 32'h20); mSel[5] = 1'b1;
    check("R5", "irq drops after route to fast", {31'd0, irqOut}, 32'd0);
    check("R5", "fiq rises after route to fast", {31'd0, fiqOut}, 32'd1);
    regWr(8'h04, 32'h0); mEn[5] = 1'b0;
    check("R5", "fiq drops after disable", {31'd0, fiqOut}, 32'd0);
    // R8 status write ignored; R1 no software clear
    regWr(8'h00, 32'h0);
    regWr(8'h0C, 32'hFFFF_FFFF);
    regWr(8'h18, 32'h0);
    regRd(8'h00); check("R1", "raw holds despite write", rd, 32'h20);
    regRd(8'h18); check("R8", "highest write ignored", rd, 32'h8000_0000);
    setSrc(64'h0);
    regRd(8'h00); check("R1", "raw clears with input", rd, 32'h0);

    // R4/R6 upper-bank mapping and lowest-index pick
    regWr(8'h04, 32'h0000_0408); regWr(8'h24, 32'h0000_0100);
    mEn = 64'h0000_0100_0000_0408;
    setSrc(64'h0000_0100_0000_0000);
    regRd(8'h2C); check("R4", "source 40 at upper bit 8", rd, 32'h100);
    regRd(8'h18); check("R6", "highest is 40", rd, 32'd40);
    setSrc(64'h0000_0100_0000_0408);
    regRd(8'h18); check("R6", "highest is 3", rd, 32'd3);
    regRd(8'h1C); check("R6", "fast line none", rd, 32'h8000_0000);

    // R7 storage
    regWr(8'h14, 32'hA5A5_5A5A);
    regRd(8'h14); check("R7", "priority storage", rd, 32'hA5A5_5A5A);
    regWr(8'h34, 32'hFFFF_FFFF);
    regRd(8'h34); check("R7", "error enable bit", rd, 32'h1);
    check("R8", "error offset in 32 build", rd32, 32'd0);
    regWr(8'h24, 32'h0000_0100);
    regRd(8'h24); check("R2", "upper enable readback", rd, 32'h100);
    check("R8", "upper enable in 32 build", rd32, 32'd0);

    // R8 unimplemented offsets
    regRd(8'h38); check("R8", "offset 0x38", rd, 32'd0);
    regRd(8'h02); check("R8", "unaligned offset", rd, 32'd0);
    regRd(8'hFC); check("R8", "offset 0xFC", rd, 32'd0);
    checkAll();

    // random traffic
    for (int it = 0; it < 200; it++) begin
      int op;
      logic [31:0] v;
      op = int'($urandom % 5);
      v = $urandom & $urandom;
      case (op)
        0: begin regWr(8'h04, v); mEn[31:0] = v; end
        1: begin regWr(8'h24, v); mEn[63:32] = v; end
        2: begin regWr(8'h08, v); mSel[31:0] = v; end
        3: begin regWr(8'h28, v); mSel[63:32] = v; end
        default: setSrc({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      endcase
      if (op < 4) begin
        regRd(op[0] ? 8'h24 : 8'h04);
        check("R2", "enable readback", rd, op[0] ? mEn[63:32] : mEn[31:0]);
        regRd(op[0] ? 8'h28 : 8'h08);
        check("R2", "select readback", rd, op[0] ? mSel[63:32] : mSel[31:0]);
      end
      checkAll();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule